// File: doc/BRIEF.md
# Three-Wire Codec Control Byte Transmitter

This block sends one byte over a three-wire codec control bus made of a mode line, a serial data line and a serial clock line. A host places an 8-bit value and a one-bit mode selector on its inputs and pulses `start`. The block captures both, drives the mode line to the requested level and waits one timing unit so the mode is settled. It then shifts the byte out starting with bit 0. The serial clock idles high and falls each time a new bit appears. The receiving codec samples on the rising edge.

Each clock half-period lasts one timing unit. A timing unit is `CYCLES_PER_UNIT` cycles of the system clock, which puts roughly 1 µs per half-period within reach of any system clock. After the eighth bit all three lines go back to their rest levels: mode high, clock high, data low. `done` pulses for one cycle and `busy` drops on the following cycle. A request that arrives while a byte is in flight is dropped.

Top module: `cw3_byte_tx`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the lines rest at mode=1, clock=1, data=0, with busy=0 and done=0. A reset in the middle of a transfer aborts it.
- R2: When `start` is sampled high with busy=0, the next cycle shows busy=1, the mode line equal to the captured `mode_in`, the clock high and the data line low.
- R3: After an accepted start the clock stays high for exactly `CYCLES_PER_UNIT` cycles before its first falling edge, and the mode line holds its new value throughout.
- R4: The byte goes out as 8 bits, least significant bit first. During bit k (k = 0..7), the data line equals bit k of the captured byte.
- R5: For every bit, the clock falls in the same cycle that the data line takes the new bit. The clock then stays low for `CYCLES_PER_UNIT` cycles.
- R6: The clock is then high for `CYCLES_PER_UNIT` cycles. The data line does not change across the rising edge or during the high half.
- R7: After the high half of bit 7 the lines return to mode=1, clock=1, data=0, and `done` is high for exactly one cycle with busy still high. Busy falls on the next cycle. An accepted transfer keeps busy high for 17·`CYCLES_PER_UNIT`+1 cycles.
- R8: `data_in` and `mode_in` are captured only on an accepted start. Later changes to them do not affect the transfer in progress.
- R9: A `start` that is sampled while busy=1, including the cycle in which `done` is high, is ignored. It neither changes the current transfer nor launches another one.
- R10: A `start` that is sampled in the first cycle after busy has dropped is accepted as a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to send one byte |
| mode_in | input | 1 | Mode level for the transfer, captured on start |
| data_in | input | BYTE_W | Byte to send, captured on start |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| done | output | 1 | One-cycle pulse marking the end of a transfer |
| line_mode | output | 1 | Bus mode line |
| line_clk | output | 1 | Bus serial clock, idles high |
| line_data | output | 1 | Bus serial data |

## Verification
Two things can happen in the same cycle: the end-of-transfer handshake (the `done` cycle) and a new `start` request. The bench raises `start` so that it is sampled exactly in the `done` cycle. It then expects the lines to stay at rest and busy to stay low afterwards. A second case raises `start` one cycle later, in the first cycle with busy low, and expects a new transfer carrying the new mode level. Every one of the 512 combinations of mode and byte is compared cycle by cycle against a waveform the bench computes from the unit length. Throughout each transfer the inputs are inverted, and extra start pulses land inside the bit phase.

// File: rtl/cw3_pkg.sv
package cw3_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SETUP    = 3'd1,
        ST_BIT_LOW  = 3'd2,
        ST_BIT_HIGH = 3'd3,
        ST_FINISH   = 3'd4
    } cw3_state_e;

    typedef struct packed {
        cw3_state_e state;
        logic       busy;
        logic       done;
        logic       mode;
        logic       sclk;
        logic       sdat;
    } cw3_ctrl_s;

    localparam cw3_ctrl_s CW3_CTRL_RESET = '{
        state: ST_IDLE,
        busy:  1'b0,
        done:  1'b0,
        mode:  1'b1,
        sclk:  1'b1,
        sdat:  1'b0
    };

endpackage

// File: rtl/cw3_unit_timer.sv
module cw3_unit_timer #(
    parameter int CYCLES_PER_UNIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(CYCLES_PER_UNIT + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_UNIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_s;

    timer_s tmr_d, tmr_q;

    always_comb begin
        tick = run && (tmr_q.cnt == LAST);
        tmr_d = tmr_q;
        if (!run || tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/cw3_bit_shifter.sv
module cw3_bit_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            advance,
    output logic            cur_bit,
    output logic            next_bit,
    output logic            last_bit
);
    localparam int IW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(BITS - 1);

    typedef struct packed {
        logic [BITS-1:0] sr;
        logic [IW-1:0]   idx;
    } shift_s;

    shift_s sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.sr  = load_val;
            sh_d.idx = '0;
        end else if (advance) begin
            sh_d.sr  = {1'b0, sh_q.sr[BITS-1:1]};
            sh_d.idx = sh_q.idx + 1'b1;
        end
    end

    assign cur_bit  = sh_q.sr[0];
    assign next_bit = sh_q.sr[1];
    assign last_bit = (sh_q.idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end
endmodule

// File: rtl/cw3_byte_tx.sv
module cw3_byte_tx #(
    parameter int CYCLES_PER_UNIT = 100,
    parameter int BYTE_W          = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic              busy,
    output logic              done,
    output logic              line_mode,
    output logic              line_clk,
    output logic              line_data
);
    import cw3_pkg::*;

    cw3_ctrl_s ctl_d, ctl_q;
    logic      unit_tick;
    logic      timer_run;
    logic      sh_load, sh_adv;
    logic      sh_cur, sh_next, sh_last;

    assign timer_run = (ctl_q.state == ST_SETUP)   ||
                       (ctl_q.state == ST_BIT_LOW) ||
                       (ctl_q.state == ST_BIT_HIGH);

    cw3_unit_timer #(
        .CYCLES_PER_UNIT(CYCLES_PER_UNIT)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .run (timer_run),
        .tick(unit_tick)
    );

    cw3_bit_shifter #(
        .BITS(BYTE_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (sh_load),
        .load_val(data_in),
        .advance (sh_adv),
        .cur_bit (sh_cur),
        .next_bit(sh_next),
        .last_bit(sh_last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        sh_load    = 1'b0;
        sh_adv     = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state = ST_SETUP;
                    ctl_d.busy  = 1'b1;
                    ctl_d.mode  = mode_in;
                    ctl_d.sclk  = 1'b1;
                    ctl_d.sdat  = 1'b0;
                    sh_load     = 1'b1;
                end
            end
            ST_SETUP: begin
                if (unit_tick) begin
                    ctl_d.state = ST_BIT_LOW;
                    ctl_d.sclk  = 1'b0;
                    ctl_d.sdat  = sh_cur;
                end
            end
            ST_BIT_LOW: begin
                if (unit_tick) begin
                    ctl_d.state = ST_BIT_HIGH;
                    ctl_d.sclk  = 1'b1;
                end
            end
            ST_BIT_HIGH: begin
                if (unit_tick) begin
                    if (sh_last) begin
                        ctl_d.state = ST_FINISH;
                        ctl_d.mode  = 1'b1;
                        ctl_d.sclk  = 1'b1;
                        ctl_d.sdat  = 1'b0;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.state = ST_BIT_LOW;
                        ctl_d.sclk  = 1'b0;
                        ctl_d.sdat  = sh_next;
                        sh_adv      = 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                ctl_d.state = ST_IDLE;
                ctl_d.busy  = 1'b0;
            end
            default: begin
                ctl_d = CW3_CTRL_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CW3_CTRL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = ctl_q.busy;
    assign done      = ctl_q.done;
    assign line_mode = ctl_q.mode;
    assign line_clk  = ctl_q.sclk;
    assign line_data = ctl_q.sdat;
endmodule

// File: rtl/cw3_byte_tx_chk.sv
module cw3_byte_tx_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic line_mode,
    input logic line_clk,
    input logic line_data
);
    // R1
    rest_levels_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (line_mode && line_clk && !line_data));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && line_clk && !line_data));

    // R5
    data_moves_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && !$fell(line_clk)) |-> $stable(line_data));

    // R6
    rise_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(line_clk) && busy) |-> $stable(line_data));

    // R7
    done_at_rest_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && line_mode && line_clk && !line_data));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R9
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy);
endmodule

bind cw3_byte_tx cw3_byte_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .line_mode(line_mode),
    .line_clk (line_clk),
    .line_data(line_data)
);

// File: tb/cw3_byte_tx_tb.sv
module cw3_byte_tx_tb;
    localparam int CPU = 3;
    localparam int TOT = 17 * CPU;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mode_in = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       busy, done, line_mode, line_clk, line_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cw3_byte_tx #(.CYCLES_PER_UNIT(CPU), .BYTE_W(8)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mode_in(mode_in), .data_in(data_in),
        .busy(busy), .done(done), .line_mode(line_mode), .line_clk(line_clk),
        .line_data(line_data)
    );

    function automatic logic [4:0] outs();
        return {busy, done, line_mode, line_clk, line_data};
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual={busy,done,mode,clk,data}=%b expected=%b", tag, act, exp);
        end
    endtask

    // expected outputs t cycles after the edge that accepted start
    function automatic logic [4:0] expect_at(int t, logic m, logic [7:0] d);
        int p, k;
        logic hi;
        if (t < CPU) return {1'b1, 1'b0, m, 1'b1, 1'b0};
        if (t < TOT) begin
            p  = t - CPU;
            k  = p / (2 * CPU);
            hi = ((p % (2 * CPU)) >= CPU);
            return {1'b1, 1'b0, m, hi, d[k]};
        end
        if (t == TOT) return 5'b11110;
        return 5'b00110;
    endfunction

    function automatic string tag_at(int t);
        int p;
        if (t == 0) return "R2";
        if (t < CPU) return "R3";
        if (t < TOT) begin
            p = t - CPU;
            if ((p % (2 * CPU)) < CPU) return "R4 R5 R8";
            return "R4 R6 R8";
        end
        if (t == TOT) return "R7";
        return "R7 R9";
    endfunction

    // one transfer; inputs are inverted after capture (R8); optional start poke
    task automatic xfer(input logic m, input logic [7:0] d, input int poke_t, input int last_t);
        @(negedge clk);
        start = 1'b1; mode_in = m; data_in = d;
        @(posedge clk);
        for (int t = 0; t <= last_t; t++) begin
            @(negedge clk);
            if (t == 0) begin
                start = 1'b0; mode_in = ~m; data_in = ~d;
            end
            if (t == poke_t + 1) start = 1'b0;
            chk(tag_at(t), outs(), expect_at(t, m, d));
            if (t == poke_t) start = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", outs(), 5'b00110);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", outs(), 5'b00110);

        // full sweep of mode and byte values (R4 R8)
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 256; d++) begin
                xfer(m[0], d[7:0], -5, TOT + 2);
            end
        end

        // R9: start pokes during setup, bit phase and the done cycle
        xfer(1'b0, 8'hA5, 1, TOT + 3);
        xfer(1'b1, 8'h3C, CPU * 8 + 1, TOT + 3);
        xfer(1'b0, 8'hF0, TOT, TOT + 3);

        // R10: start in the first cycle after busy drops
        xfer(1'b0, 8'h96, TOT + 1, TOT + 1);
        @(negedge clk);
        start = 1'b0;
        chk("R10 accepted", outs(), 5'b10110);
        for (int i = 0; i < TOT + 4 && busy; i++) @(negedge clk);
        chk("R10 completes", outs(), 5'b00110);

        // R1: reset in mid-transfer
        @(negedge clk);
        start = 1'b1; mode_in = 1'b0; data_in = 8'hFF;
        @(negedge clk);
        start = 1'b0;
        repeat (CPU * 4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-transfer reset", outs(), 5'b00110);
        rst = 1'b0;
        repeat (CPU * 2) @(negedge clk);
        chk("R1 stays idle", outs(), 5'b00110);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule